// File: doc/BRIEF.md
# Sector-Erasable Flash Command and Erase Controller

This block holds the control logic of a byte-wide NOR flash, with the cell array reduced to a small on-chip memory. A host drives chip-select, write-strobe and read-strobe lines, a byte address and a byte of write data. Bus writes feed a command decoder. The decoder demands a two-step key before it accepts any program or erase command. A sequencer then runs the chosen operation with cycle counters that stand in for the analog program and erase pulses. Programming can only clear bits. Erasing returns bytes to 0xFF.

An erase targets either a set of sectors, gathered during a short collection window, or the whole array. The erase first drives every targeted byte to 0x00, then runs a pulse interval, then sets the targeted bytes to 0xFF, then runs a verify interval. An erase in progress can be suspended. While it is suspended, the host can read or program sectors outside the erase set. A resume command continues the erase from the point where it stopped.

Sectors are grouped for write protection. A protected group takes neither program nor erase unless the temporary-unprotect input is high. While an operation runs, a read returns a status byte instead of array data, and a registered ready line stays low.

Top module: `flash_ctl`

## Requirements
- R1: After reset, `ready` is 1, `dout` is 0x00, and the controller is in array-read mode.
- R2: A read is a cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1. When no operation is running, the addressed array byte appears on `dout` two rising edges after the read cycle.
- R3: A command starts with two key writes: 0xAA at address 85, then 0x55 at address 42. A third write at address 85 then selects the command: 0xA0 for program or 0x80 for erase. If a key cycle carries any other address or data, the decoder returns to read mode and the command is dropped.
- R4: A program command takes a fourth write that carries the target address and the data byte. The stored byte becomes the old byte AND the new data, so programming can only clear bits.
- R5: `ready` goes low while a program, an erase collection window or an erase sequence is running. It returns high when the operation ends.
- R6: A read made while an operation runs returns a status byte. Bits 5 to 0 are 0. Bit 7 is the inverse of bit 7 of the data being programmed, or 0 during an erase.
- R7: Bit 6 of the status byte flips between consecutive status reads.
- R8: An erase command is the erase key sequence followed by the two key writes again. A write of 0x30 at an address in a sector selects that sector. Further 0x30 writes before 16 idle cycles have passed add more sectors. When the erase ends, every byte of the selected sectors reads 0xFF and other sectors are unchanged.
- R9: The erase key sequence followed by the two key writes and 0x10 at address 85 erases every sector that is not protected.
- R10: `prot_mask` bit g protects sectors 4g to 4g+3 (16 bytes per group). A program or erase aimed at a protected sector leaves the data unchanged unless `unprot_tmp` is 1.
- R11: During an erase (not in the collection window), a write of 0xB0 suspends it and `ready` goes high. Reads of sectors in the erase set then return 0x80. Other sectors can be read and programmed. A write of 0x30 resumes the erase, which then completes.
- R12: Asserting `rst` aborts any running operation. `ready` is high on the next cycle, and data that the aborted program had not yet written is unchanged.
- R13: While `low_vcc` is 1, bus writes are ignored: no command starts and `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also aborts operations |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | 7 | Byte address; the upper 5 bits select the sector |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Registered read data or status byte |
| ready | output | 1 | High when no operation is running |
| low_vcc | input | 1 | Supply-low indication; blocks writes |
| prot_mask | input | 8 | One protect bit per group of four sectors |
| unprot_tmp | input | 1 | Temporarily lifts group protection |

## Verification
The assertions assume that `prot_mask` and `unprot_tmp` stay constant while a program or erase is in flight. The protection filter is applied when a command is accepted, so a later change in these inputs would make a correct write look illegal. They also assume that no read and write are requested in the same cycle. The stimulus changes protection only between operations, always waits for `ready` to return high before it reconfigures, and drives one strobe at a time.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam logic [7:0] KEY_LO   = 8'hAA;
  localparam logic [7:0] KEY_HI   = 8'h55;
  localparam logic [7:0] CMD_PROG = 8'hA0;
  localparam logic [7:0] CMD_ERS  = 8'h80;
  localparam logic [7:0] CMD_CHIP = 8'h10;
  localparam logic [7:0] CMD_SECT = 8'h30;
  localparam logic [7:0] CMD_SUSP = 8'hB0;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_SECT, OP_CHIP, OP_SUSP, OP_RESUME
  } op_e;

  typedef enum logic [2:0] {
    D_READ, D_K1, D_K2, D_PDATA, D_E0, D_E1, D_E2
  } dec_e;

  typedef enum logic [2:0] {
    P_IDLE, P_RUN, P_WR, P_VER, P_CHK
  } prg_e;

  typedef enum logic [2:0] {
    EP_IDLE, EP_WIN, EP_PRE, EP_PULSE, EP_ERASE, EP_VERIFY
  } eph_e;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rq
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec import flash_ctl_pkg::*; #(
  parameter int AW     = 7,
  parameter int KEY_A1 = 85,
  parameter int KEY_A2 = 42
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic          prog_busy,
  input  logic          ers_run,
  input  logic          ers_win,
  input  logic          ers_susp,
  output op_e           op,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  localparam logic [AW-1:0] A1 = AW'(KEY_A1);
  localparam logic [AW-1:0] A2 = AW'(KEY_A2);

  dec_e st;
  logic k1_hit, k2_hit;
  assign k1_hit = (wa == A1) && (wd == KEY_LO);
  assign k2_hit = (wa == A2) && (wd == KEY_HI);

  always_ff @(posedge clk) begin
    op <= OP_NONE;
    if (rst) begin
      st      <= D_READ;
      op_addr <= '0;
      op_data <= '0;
    end else if (wr_en) begin
      op_addr <= wa;
      op_data <= wd;
      if (prog_busy) begin
        st <= D_READ;
      end else if (ers_win) begin
        if (wd == CMD_SECT) op <= OP_SECT;
      end else if (ers_run) begin
        if (wd == CMD_SUSP) op <= OP_SUSP;
      end else begin
        unique case (st)
          D_READ:  if (ers_susp && wd == CMD_SECT) op <= OP_RESUME;
                   else if (k1_hit) st <= D_K1;
          D_K1:    st <= k2_hit ? D_K2 : D_READ;
          D_K2:    if (wa == A1 && wd == CMD_PROG) st <= D_PDATA;
                   else if (wa == A1 && wd == CMD_ERS && !ers_susp) st <= D_E0;
                   else st <= D_READ;
          D_PDATA: begin op <= OP_PROG; st <= D_READ; end
          D_E0:    st <= k1_hit ? D_E1 : D_READ;
          D_E1:    st <= k2_hit ? D_E2 : D_READ;
          D_E2:    begin
                     if (wa == A1 && wd == CMD_CHIP) op <= OP_CHIP;
                     else if (wd == CMD_SECT) op <= OP_SECT;
                     st <= D_READ;
                   end
          default: st <= D_READ;
        endcase
      end
    end
  end

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    prog_busy |=> (op == OP_NONE)); // R3
endmodule

// File: rtl/flash_seq.sv
module flash_seq import flash_ctl_pkg::*; #(
  parameter int AW        = 7,
  parameter int NSECT     = 32,
  parameter int NGRP      = 8,
  parameter int PROG_CYC  = 24,
  parameter int PULSE_CYC = 40,
  parameter int VER_CYC   = 8,
  parameter int WIN_CYC   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [AW-1:0]    op_addr,
  input  logic [7:0]       op_data,
  input  logic [NGRP-1:0]  prot_mask,
  input  logic             unprot,
  input  logic [7:0]       rd_q,
  output logic             prog_busy,
  output logic             ers_run,
  output logic             ers_win,
  output logic             ers_susp,
  output logic [NSECT-1:0] ers_mask,
  output logic             poll_bit,
  output logic [AW-1:0]    prog_addr,
  output logic             mem_we,
  output logic [AW-1:0]    mem_wa,
  output logic [7:0]       mem_wd
);
  localparam int SW  = $clog2(NSECT);
  localparam int SPG = NSECT / NGRP;
  localparam int CW  = $clog2(PROG_CYC + PULSE_CYC + VER_CYC + WIN_CYC + 1) + 1;

  logic [NSECT-1:0] open_mask;
  for (genvar i = 0; i < NSECT; i++) begin : g_open
    assign open_mask[i] = unprot || !prot_mask[i / SPG];
  end

  prg_e pst;
  eph_e eph;
  logic [CW-1:0] pcnt, ecnt;
  logic [7:0] pdata, ptarget;
  logic [AW-1:0] waddr;
  logic [SW-1:0] op_sect;
  logic e_we;

  assign op_sect   = op_addr[AW-1 -: SW];
  assign prog_busy = (pst != P_IDLE);
  assign ers_win   = (eph == EP_WIN);
  assign ers_run   = (eph != EP_IDLE) && (eph != EP_WIN) && !ers_susp;
  assign poll_bit  = pdata[7];
  assign e_we      = ers_run && (eph == EP_PRE || eph == EP_ERASE)
                     && ers_mask[waddr[AW-1 -: SW]];
  assign mem_we    = (pst == P_WR) || e_we;
  assign mem_wa    = (pst == P_WR) ? prog_addr : waddr;
  assign mem_wd    = (pst == P_WR) ? (rd_q & pdata) : ((eph == EP_PRE) ? 8'h00 : 8'hFF);

  // program sequence: wait, write, read back, compare
  always_ff @(posedge clk) begin
    if (rst) begin
      pst       <= P_IDLE;
      pcnt      <= '0;
      pdata     <= '1;
      ptarget   <= '0;
      prog_addr <= '0;
    end else begin
      unique case (pst)
        P_IDLE: if (op == OP_PROG && open_mask[op_sect] && !ers_run && !ers_win
                    && !(ers_susp && ers_mask[op_sect])) begin
                  pst       <= P_RUN;
                  prog_addr <= op_addr;
                  pdata     <= op_data;
                  pcnt      <= CW'(PROG_CYC);
                end
        P_RUN:  if (pcnt == '0) pst <= P_WR; else pcnt <= pcnt - 1'b1;
        P_WR:   begin ptarget <= rd_q & pdata; pst <= P_VER; end
        P_VER:  pst <= P_CHK;
        P_CHK:  pst <= (rd_q == ptarget) ? P_IDLE : P_WR;
        default: pst <= P_IDLE;
      endcase
    end
  end

  // erase sequence: window, preprogram walk, pulse, erase walk, verify
  always_ff @(posedge clk) begin
    if (rst) begin
      eph      <= EP_IDLE;
      ers_mask <= '0;
      ers_susp <= 1'b0;
      ecnt     <= '0;
      waddr    <= '0;
    end else begin
      if (op == OP_SUSP && ers_run) ers_susp <= 1'b1;
      if (op == OP_RESUME && ers_susp && pst == P_IDLE) ers_susp <= 1'b0;
      unique case (eph)
        EP_IDLE: if (pst == P_IDLE && op == OP_SECT) begin
                   ers_mask <= open_mask & (NSECT'(1) << op_sect);
                   ecnt     <= CW'(WIN_CYC);
                   eph      <= EP_WIN;
                 end else if (pst == P_IDLE && op == OP_CHIP) begin
                   ers_mask <= open_mask;
                   waddr    <= '0;
                   eph      <= EP_PRE;
                 end
        EP_WIN:  if (op == OP_SECT) begin
                   ers_mask[op_sect] <= ers_mask[op_sect] | open_mask[op_sect];
                   ecnt <= CW'(WIN_CYC);
                 end else if (ecnt == '0) begin
                   waddr <= '0;
                   eph   <= (|ers_mask) ? EP_PRE : EP_IDLE;
                 end else ecnt <= ecnt - 1'b1;
        EP_PRE:  if (!ers_susp) begin
                   waddr <= waddr + 1'b1;
                   if (&waddr) begin eph <= EP_PULSE; ecnt <= CW'(PULSE_CYC); end
                 end
        EP_PULSE: if (!ers_susp) begin
                   if (ecnt == '0) begin eph <= EP_ERASE; waddr <= '0; end
                   else ecnt <= ecnt - 1'b1;
                 end
        EP_ERASE: if (!ers_susp) begin
                   waddr <= waddr + 1'b1;
                   if (&waddr) begin eph <= EP_VERIFY; ecnt <= CW'(VER_CYC); end
                 end
        EP_VERIFY: if (!ers_susp) begin
                   if (ecnt == '0) begin eph <= EP_IDLE; ers_mask <= '0; end
                   else ecnt <= ecnt - 1'b1;
                 end
        default: eph <= EP_IDLE;
      endcase
    end
  end

  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> open_mask[mem_wa[AW-1 -: SW]]); // R10
  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (ers_susp && mem_we) |-> !ers_mask[mem_wa[AW-1 -: SW]]); // R11
  AST_PROG_ERS_EXCL: assert property (@(posedge clk) disable iff (rst)
    prog_busy |-> !ers_run); // R11
  AST_VERIFY_PASS: assert property (@(posedge clk) disable iff (rst)
    (pst == P_CHK) |-> (rd_q == ptarget)); // R4
endmodule

// File: rtl/flash_ctl.sv
module flash_ctl import flash_ctl_pkg::*; #(
  parameter int NSECT      = 32,
  parameter int SECT_BYTES = 4,
  parameter int NGRP       = 8,
  parameter int PROG_CYC   = 24,
  parameter int PULSE_CYC  = 40,
  parameter int VER_CYC    = 8,
  parameter int WIN_CYC    = 16,
  parameter int KEY_A1     = 85,
  parameter int KEY_A2     = 42,
  localparam int AW        = $clog2(NSECT * SECT_BYTES),
  localparam int SW        = $clog2(NSECT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic            ready,
  input  logic            low_vcc,
  input  logic [NGRP-1:0] prot_mask,
  input  logic            unprot_tmp
);
  logic wr_req, rd_req;
  assign wr_req = !ce_n && !we_n && oe_n && !low_vcc;
  assign rd_req = !ce_n && !oe_n && we_n;

  op_e dec_op;
  logic [AW-1:0] op_addr, prog_addr, mem_wa, rd_addr;
  logic [7:0] op_data, mem_wd, rq;
  logic [NSECT-1:0] ers_mask;
  logic prog_busy, ers_run, ers_win, ers_susp, poll_bit, mem_we, busy;

  flash_cmd_dec #(.AW(AW), .KEY_A1(KEY_A1), .KEY_A2(KEY_A2)) u_dec (
    .clk, .rst, .wr_en(wr_req), .wa(addr), .wd(din),
    .prog_busy, .ers_run, .ers_win, .ers_susp,
    .op(dec_op), .op_addr, .op_data);

  flash_seq #(.AW(AW), .NSECT(NSECT), .NGRP(NGRP), .PROG_CYC(PROG_CYC),
    .PULSE_CYC(PULSE_CYC), .VER_CYC(VER_CYC), .WIN_CYC(WIN_CYC)) u_seq (
    .clk, .rst, .op(dec_op), .op_addr, .op_data, .prot_mask, .unprot(unprot_tmp),
    .rd_q(rq), .prog_busy, .ers_run, .ers_win, .ers_susp, .ers_mask, .poll_bit,
    .prog_addr, .mem_we, .mem_wa, .mem_wd);

  assign rd_addr = prog_busy ? prog_addr : addr;

  flash_array #(.AW(AW)) u_arr (
    .clk, .we(mem_we), .wa(mem_wa), .wd(mem_wd), .ra(rd_addr), .rq);

  assign busy = prog_busy || ers_run || ers_win;

  logic rd_v, use_stat, tog;
  logic [7:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b1;
      rd_v     <= 1'b0;
      use_stat <= 1'b0;
      stat_q   <= '0;
      tog      <= 1'b0;
      dout     <= '0;
    end else begin
      ready <= !busy;
      rd_v  <= rd_req;
      if (rd_req) begin
        if (busy) begin
          use_stat <= 1'b1;
          stat_q   <= {prog_busy ? ~poll_bit : 1'b0, tog, 6'b0};
          tog      <= ~tog;
        end else if (ers_susp && ers_mask[addr[AW-1 -: SW]]) begin
          use_stat <= 1'b1;
          stat_q   <= 8'h80;
        end else begin
          use_stat <= 1'b0;
        end
      end
      if (rd_v) dout <= use_stat ? stat_q : rq;
    end
  end

  AST_LOWV_BLOCK: assert property (@(posedge clk) disable iff (rst)
    low_vcc |=> (dec_op == OP_NONE)); // R13
endmodule

// File: tb/flash_ctl_tb.sv
module flash_ctl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic ready;
  logic low_vcc = 1'b0;
  logic [7:0] prot_mask = '0;
  logic unprot_tmp = 1'b0;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  flash_ctl u_dut (.clk, .rst, .ce_n, .we_n, .oe_n, .addr, .din, .dout, .ready,
                   .low_vcc, .prot_mask, .unprot_tmp);

  // address, program data, expected readback
  localparam logic [22:0] VEC [8] = '{
    {7'h00, 8'hA5, 8'hA5}, {7'h00, 8'h0F, 8'h05}, {7'h7F, 8'h3C, 8'h3C},
    {7'h40, 8'h00, 8'h00}, {7'h41, 8'hFF, 8'hFF}, {7'h00, 8'hF0, 8'h00},
    {7'h23, 8'h81, 8'h81}, {7'h23, 8'h7E, 8'h00}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [7:0] q);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); q = dout;
  endtask

  task automatic wait_ready();
    int n = 0;
    repeat (3) @(negedge clk);
    while (!ready && n < 5000) begin @(negedge clk); n++; end
    if (!ready) check("R5 ready timeout", {7'b0, ready}, 8'h01);
  endtask

  task automatic keys();
    bus_wr(7'd85, 8'hAA); bus_wr(7'd42, 8'h55);
  endtask

  task automatic prog(input logic [6:0] a, input logic [7:0] d);
    keys(); bus_wr(7'd85, 8'hA0); bus_wr(a, d);
  endtask

  task automatic ers_hdr();
    keys(); bus_wr(7'd85, 8'h80); keys();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q, s1, s2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", {7'b0, ready}, 8'h01);
    check("R1 dout after reset", dout, 8'h00);

    // R9 chip erase as initialisation
    ers_hdr(); bus_wr(7'd85, 8'h10);
    wait_ready();
    bus_rd(7'h00, q); check("R9 chip erase low", q, 8'hFF);
    bus_rd(7'h7F, q); check("R2 R9 chip erase high", q, 8'hFF);

    // R4 vector walk
    for (int i = 0; i < 8; i++) begin
      prog(VEC[i][22:16], VEC[i][15:8]);
      wait_ready();
      bus_rd(VEC[i][22:16], q);
      check("R4 program vector", q, VEC[i][7:0]);
    end

    // R5 R6 R7 polling during program
    prog(7'h50, 8'h12);
    repeat (2) @(negedge clk);
    check("R5 ready low in program", {7'b0, ready}, 8'h00);
    bus_rd(7'h50, s1); bus_rd(7'h50, s2);
    check("R6 poll bit7", {s1[7], s1[5:0]}, {1'b1, 6'b0});
    check("R7 toggle", {7'b0, s1[6] ^ s2[6]}, 8'h01);
    wait_ready();
    check("R5 ready high after program", {7'b0, ready}, 8'h01);
    bus_rd(7'h50, q); check("R4 after poll", q, 8'h12);

    // R3 wrong key sequence
    bus_wr(7'd85, 8'hAA); bus_wr(7'd42, 8'h54); bus_wr(7'd85, 8'hA0); bus_wr(7'h12, 8'h00);
    repeat (4) @(negedge clk);
    check("R3 bad key ready", {7'b0, ready}, 8'h01);
    bus_rd(7'h12, q); check("R3 bad key data", q, 8'hFF);

    // R13 low supply blocks writes
    low_vcc = 1'b1;
    prog(7'h11, 8'h00);
    repeat (4) @(negedge clk);
    check("R13 ready stays high", {7'b0, ready}, 8'h01);
    low_vcc = 1'b0;
    bus_rd(7'h11, q); check("R13 data unchanged", q, 8'hFF);

    // R8 multi-sector erase, R6 erase status
    prog(7'h30, 8'h11); wait_ready();
    prog(7'h60, 8'h33); wait_ready();
    ers_hdr(); bus_wr(7'h30, 8'h30); bus_wr(7'h51, 8'h30);
    repeat (24) @(negedge clk);
    bus_rd(7'h30, q); check("R6 erase status", {q[7], q[5:0]}, 7'h00);
    wait_ready();
    bus_rd(7'h30, q); check("R8 first sector", q, 8'hFF);
    bus_rd(7'h50, q); check("R8 second sector", q, 8'hFF);
    bus_rd(7'h60, q); check("R8 other sector kept", q, 8'h33);

    // R10 protection and temporary unprotect
    prog(7'd20, 8'h5A); wait_ready();
    prot_mask = 8'h02;
    prog(7'd20, 8'h00); wait_ready();
    bus_rd(7'd20, q); check("R10 protected program", q, 8'h5A);
    ers_hdr(); bus_wr(7'd20, 8'h30); wait_ready();
    bus_rd(7'd20, q); check("R10 protected erase", q, 8'h5A);
    unprot_tmp = 1'b1;
    prog(7'd20, 8'h0F); wait_ready();
    bus_rd(7'd20, q); check("R10 temp unprotect", q, 8'h0A);
    unprot_tmp = 1'b0; prot_mask = 8'h00;

    // R11 suspend and resume
    prog(7'h0C, 8'h44); wait_ready();
    prog(7'h24, 8'h77); wait_ready();
    ers_hdr(); bus_wr(7'h0C, 8'h30);
    repeat (22) @(negedge clk);
    bus_wr(7'h00, 8'hB0);
    repeat (3) @(negedge clk);
    check("R11 ready in suspend", {7'b0, ready}, 8'h01);
    bus_rd(7'h24, q); check("R11 read other sector", q, 8'h77);
    bus_rd(7'h0C, q); check("R11 read erasing sector", q, 8'h80);
    prog(7'h25, 8'h12); wait_ready();
    bus_rd(7'h25, q); check("R11 program in suspend", q, 8'h12);
    bus_wr(7'h00, 8'h30);
    repeat (3) @(negedge clk);
    check("R11 resumed busy", {7'b0, ready}, 8'h00);
    wait_ready();
    bus_rd(7'h0C, q); check("R11 erase completed", q, 8'hFF);
    bus_rd(7'h24, q); check("R11 other kept", q, 8'h77);

    // R9 chip erase skips protected group 2
    prot_mask = 8'h04;
    ers_hdr(); bus_wr(7'd85, 8'h10); wait_ready();
    bus_rd(7'h00, q); check("R9 chip erase", q, 8'hFF);
    bus_rd(7'h24, q); check("R9 R10 protected kept", q, 8'h77);
    prot_mask = 8'h00;

    // R12 reset aborts program
    prog(7'h10, 8'h00);
    repeat (4) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R12 ready after abort", {7'b0, ready}, 8'h01);
    bus_rd(7'h10, q); check("R12 data unchanged", q, 8'hFF);
    prog(7'h10, 8'h3F); wait_ready();
    bus_rd(7'h10, q); check("R12 read mode after abort", q, 8'h3F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule